// File: doc/BRIEF.md
# Frame-Based Pulse-Width Modulator Cell

This cell drives one pin with a pulse train. It uses two down-counters. The frame counter sets the period and reloads when it reaches zero. The on-time counter sets how long the pin stays high in each frame. When it reaches zero it stays there until the next reload. The pin is high while the on-time counter holds a nonzero value. The period and the duty cycle therefore come from two counters that step independently of each other. Nothing is compared against a free-running counter.

Software, or a neighbouring controller, programs a frame length and an on-time through a small write port. The programmed values sit in holding registers until the next reload, so a new setting never breaks the frame that is running. A force-reload input starts a new frame at once. A single enable freezes both counters, and an active-low synchronous reset returns the cell to idle with the pin low.

Top module: `pwm_frame_cell`

## Requirements
- R1: On an enabled clock edge where the frame counter is zero, the frame counter loads the programmed frame length F and the on-time counter loads the programmed on-time T.
- R2: On an enabled clock edge where the frame counter is nonzero and force-reload is low, the frame counter decrements by one. Each frame therefore lasts F+1 cycles.
- R3: On an enabled edge without a reload, the on-time counter decrements by one if it is nonzero and holds at zero if it is zero.
- R4: `pin_out` is high exactly while the on-time counter is nonzero. With T no greater than F+1, each frame holds the pin high for exactly T cycles, and those cycles come first in the frame.
- R5: When `force_reload` is high on an enabled edge, both counters take the programmed values whatever the frame counter holds.
- R6: While `en` is low, both counters hold their values and `pin_out` does not change. Register writes are still accepted during this time.
- R7: While `rst_n` is low at a clock edge, both counters and both programmed registers are cleared, and `pin_out` is low.
- R8: A write with `wr_sel`=0 sets the frame length and a write with `wr_sel`=1 sets the on-time. A written value reaches the counters only at a later reload. A reload on the same edge as the write uses the value held before that edge.
- R9: With T=0 the pin stays low in every frame. With T greater than F the pin stays high without a break across reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Counter enable; low freezes both counters |
| force_reload | input | 1 | Reload both counters on this edge |
| wr_en | input | 1 | Write strobe for the programmed registers |
| wr_sel | input | 1 | Write target: 0 frame length, 1 on-time |
| wr_data | input | W | Value to write |
| pin_out | output | 1 | Pulse output |

## Verification
The hardest case to reach is a write that arrives while a frame is running, and in particular one that lands on the same edge as the zero-triggered reload. That case shows whether the counters take the old or the new value. The stimulus sets a short frame and then changes the frame length and the on-time at several offsets inside the frame, one of them timed onto the reload edge. A cycle-accurate reference model follows every edge, so any early or late adoption of a new value shows up as a mismatch on the pin. Force-reload pulses and enable gaps are placed in the middle of frames so that the normal sequence is broken at points other than its own boundaries.

// File: rtl/pwm_cell_pkg.sv
// Package: shared definitions for the frame-based PWM cell.
// Assumes: nothing beyond a 1-bit write select.
package pwm_cell_pkg;
    // Write target selected by wr_sel
    typedef enum logic {
        SEL_FRAME  = 1'b0,
        SEL_ONTIME = 1'b1
    } wr_target_e;
endpackage

// File: rtl/pwm_prog_regs.sv
// Module: holding registers for frame length and on-time.
// Assumes: writes land on the clock edge and are independent of enable;
// the counters sample these registers only when they reload.
module pwm_prog_regs
    import pwm_cell_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] frame_q,
    output logic [W-1:0] ontime_q
);
    // Capture writes into the selected holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q  <= '0;
            ontime_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_ONTIME) ontime_q <= wr_data;
            else                      frame_q  <= wr_data;
        end
    end

    // R8: a write without a strobe leaves both registers unchanged
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(frame_q) && $stable(ontime_q)));
endmodule

// File: rtl/pwm_frame_ctr.sv
// Module: frame down-counter X; decides when the cell reloads.
// Assumes: reload happens on an enabled edge with X at zero or force asserted.
module pwm_frame_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         force_reload,
    input  logic [W-1:0] frame_q,
    output logic [W-1:0] x_q,
    output logic         reload
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Reload request for both counters
    always_comb reload = en && ((x_q == '0) || force_reload);

    // Step the frame counter
    always_ff @(posedge clk) begin
        if (!rst_n)      x_q <= '0;
        else if (reload) x_q <= frame_q;
        else if (en)     x_q <= x_q - ONE;
    end

    // R2: a nonzero counter steps down by one without a force
    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !force_reload && x_q != '0) |=> (x_q == $past(x_q) - ONE));

    // R6: frozen while enable is low
    a_r6_freeze_x: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(x_q));
endmodule

// File: rtl/pwm_ontime_ctr.sv
// Module: on-time down-counter Y; saturates at zero between reloads.
// Assumes: reload already includes the enable qualification.
module pwm_ontime_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         reload,
    input  logic [W-1:0] ontime_q,
    output logic [W-1:0] y_q
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Step the on-time counter, holding at zero
    always_ff @(posedge clk) begin
        if (!rst_n)                 y_q <= '0;
        else if (reload)            y_q <= ontime_q;
        else if (en && y_q != '0)   y_q <= y_q - ONE;
    end

    // R3: zero holds until a reload
    a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && y_q == '0) |=> (y_q == '0));

    // R1: a reload takes the programmed on-time
    a_r1_load_ontime: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (y_q == $past(ontime_q)));

    // R6: frozen while enable is low
    a_r6_freeze_y: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(y_q));
endmodule

// File: rtl/pwm_frame_cell.sv
// Module: top of the frame-based PWM cell.
// Assumes: one pin per instance; the pin follows the on-time counter.
module pwm_frame_cell #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         force_reload,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         pin_out
);
    logic [W-1:0] frame_q;
    logic [W-1:0] ontime_q;
    logic [W-1:0] x_q;
    logic [W-1:0] y_q;
    logic         reload;

    pwm_prog_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .frame_q(frame_q), .ontime_q(ontime_q)
    );

    pwm_frame_ctr #(.W(W)) u_xctr (
        .clk(clk), .rst_n(rst_n), .en(en), .force_reload(force_reload),
        .frame_q(frame_q), .x_q(x_q), .reload(reload)
    );

    pwm_ontime_ctr #(.W(W)) u_yctr (
        .clk(clk), .rst_n(rst_n), .en(en), .reload(reload),
        .ontime_q(ontime_q), .y_q(y_q)
    );

    // Pin is high while on-time remains
    always_comb pin_out = (y_q != '0);

    // R1: a reload takes the programmed frame length
    a_r1_load_frame: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (x_q == $past(frame_q)));

    // R9: a zero on-time reload leaves the pin low
    a_r9_zero_ontime: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && ontime_q == '0) |=> !pin_out);

    // R6: pin steady while disabled
    a_r6_pin_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pin_out));
endmodule

// File: tb/pwm_frame_cell_tb.sv
`timescale 1ns/1ps
module pwm_frame_cell_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         force_reload = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         pin_out;

    int    total = 0;
    int    bad = 0;
    string phase = "R7";
    bit    done = 0;
    bit    exp_q[$];

    // reference state from the requirements
    logic [W-1:0] m_f = '0, m_t = '0, m_x = '0, m_y = '0;

    always #2.5 clk = ~clk;

    pwm_frame_cell #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .force_reload(force_reload),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .pin_out(pin_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // driver-side model: advance per edge, push expected pin
    always @(posedge clk) begin
        if (!rst_n) begin
            m_x = '0; m_y = '0; m_f = '0; m_t = '0;
        end else begin
            if (en) begin
                if (m_x == '0 || force_reload) begin
                    m_x = m_f; m_y = m_t;
                end else begin
                    m_x = m_x - 1;
                    if (m_y != '0) m_y = m_y - 1;
                end
            end
            if (wr_en) begin
                if (wr_sel) m_t = wr_data; else m_f = wr_data;
            end
        end
        exp_q.push_back(m_y != '0);
    end

    // monitor: compare pin against the scoreboard away from the edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            check(pin_out === e, phase, int'(pin_out), int'(e));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input bit sel, input int val);
        wr_sel = sel; wr_data = W'(val); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_force;
        force_reload = 1'b1;
        @(negedge clk);
        force_reload = 1'b0;
    endtask

    // count high samples over n cycles
    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin_out === 1'b1) hi++;
        end
    endtask

    initial begin
        int hi;
        bit held;
        // R7: reset state
        cyc(3);
        check(pin_out === 1'b0, "R7 reset pin", int'(pin_out), 0);
        rst_n = 1'b1;
        en = 1'b1;
        cyc(3);
        check(pin_out === 1'b0, "R7 cleared regs keep pin low", int'(pin_out), 0);

        // R1 R2 R3 R4: F=9 T=3 -> 3 high per 10-cycle frame
        phase = "R4";
        wr(1'b0, 9);
        wr(1'b1, 3);
        pulse_force;
        count_high(10, hi);
        check(hi == 3, "R1 R2 R3 R4 high per frame", hi, 3);
        count_high(20, hi);
        check(hi == 6, "R4 two frames", hi, 6);

        // R8: mid-frame writes, including one timed onto a reload edge
        phase = "R8";
        wr(1'b0, 4);
        cyc(3);
        wr(1'b1, 2);
        cyc(17);
        pulse_force;
        count_high(5, hi);
        check(hi == 2, "R8 new settings after reload", hi, 2);
        for (int k = 0; k < 6; k++) begin
            wr(1'b1, k % 4);
            cyc(k);
        end
        cyc(12);

        // R5: force reload mid frame
        phase = "R5";
        wr(1'b0, 7);
        wr(1'b1, 5);
        cyc(3);
        pulse_force;
        count_high(8, hi);
        check(hi == 5, "R5 force restarts frame", hi, 5);

        // R6: enable low freezes
        phase = "R6";
        pulse_force;
        cyc(2);
        en = 1'b0;
        held = pin_out;
        wr(1'b1, 0);
        hi = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (pin_out !== held) hi++;
        end
        check(hi == 0, "R6 pin frozen", hi, 0);
        en = 1'b1;
        cyc(20);

        // R9: zero on-time and oversize on-time
        phase = "R9";
        wr(1'b0, 5);
        wr(1'b1, 0);
        pulse_force;
        count_high(30, hi);
        check(hi == 0, "R9 zero on-time low", hi, 0);
        wr(1'b1, 20);
        pulse_force;
        count_high(30, hi);
        check(hi == 30, "R9 long on-time high", hi, 30);
        wr(1'b1, 6);
        pulse_force;
        count_high(30, hi);
        check(hi == 30, "R9 on-time F+1 high", hi, 30);

        // R7: reset mid-run
        phase = "R7";
        rst_n = 1'b0;
        cyc(2);
        check(pin_out === 1'b0, "R7 reset mid run", int'(pin_out), 0);
        rst_n = 1'b1;
        cyc(10);
        check(pin_out === 1'b0, "R7 regs cleared", int'(pin_out), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #(5 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule